// File: doc/BRIEF.md
# Execute-Stage Operand Bypass Selector

This block sits at the entry of the execute stage of a five-stage pipelined processor. It picks the two operands that the ALU consumes in the current cycle. Each operand comes from a three-way multiplexer, and a small comparator network steers both multiplexers.

The upper operand is the next-sequential program counter, register operand A, or load data returning from the memory/write-back latch. The lower operand is the sign-extended immediate, register operand B, or the ALU result held in the execute/memory latch. The steering logic decodes the opcode of the instruction in the decode/execute latch. It compares that instruction's source register fields against the destination fields of the two older instructions still in flight.

The block holds no state. Both operands follow their inputs within the same cycle. The immediate is built inside the block from the decode/execute instruction word, so no separate immediate input is needed.

Top module: `alu_operand_fwd`

## Requirements
- R1: Instruction fields sit at fixed bit positions. The opcode is [31:26], source 1 is [25:21] and source 2 is [20:16]. The register-format destination is [15:11] and the immediate-format destination is [20:16]. Opcode 0x00 is the register format, 0x23 is a load, 0x2B is a store and 0x08 to 0x0F are immediate ALU operations. 0x04 and 0x05 are branches, 0x02 and 0x03 are jumps, and every other opcode is unrecognised.
- R2: The lower operand equals the execute/memory ALU result when three conditions hold: the decode/execute instruction is register-format, the execute/memory instruction is register-format, and the latter's destination [15:11] equals either source field of the former.
- R3: When R2 does not apply, the lower operand is the immediate for immediate ALU, load, store, branch and jump opcodes. It is register operand B for register-format and unrecognised opcodes.
- R4: The immediate is bits [15:0] sign-extended to 32 bits for every opcode except jumps. For jumps it is bits [25:0] sign-extended to 32 bits.
- R5: For branch and jump opcodes the upper operand is the next-sequential PC, even when a load bypass would otherwise match.
- R6: For any other opcode, the upper operand is the memory/write-back load data when that instruction is a load whose destination [20:16] equals source 1 of the decode/execute instruction. Otherwise the upper operand is register operand A.
- R7: When the execute/memory instruction is register-format and its destination also equals source 1, the younger result wins. The load bypass of R6 is then withheld and the upper operand is register operand A.
- R8: A destination field of 0 never produces a bypass on either operand.
- R9: Both operands change in the same cycle as their inputs, with no clock edge between input and output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| idex_instr | input | 32 | Instruction word in the decode/execute latch |
| idex_a | input | 32 | Register operand A read for that instruction |
| idex_b | input | 32 | Register operand B read for that instruction |
| idex_npc | input | 32 | Next-sequential PC carried with that instruction |
| exmem_instr | input | 32 | Instruction word in the execute/memory latch |
| exmem_result | input | 32 | ALU result in the execute/memory latch |
| memwb_instr | input | 32 | Instruction word in the memory/write-back latch |
| memwb_load_data | input | 32 | Load data in the memory/write-back latch |
| opnd_up | output | 32 | Upper ALU operand |
| opnd_lo | output | 32 | Upper ALU operand's partner, the lower ALU operand |

## Verification
The hardest condition to reach is R7. It needs three instructions to line up at once: a register-format instruction in the execute/memory latch, a load in the memory/write-back latch, and a non-flow instruction in the decode/execute latch, with the same nonzero register named in all three. Uniform random fields almost never produce this, so the random generator draws register numbers from a pool of four values. That pool includes 0, which also exercises R8 often. The generator also weights the opcode draw towards register-format and load words, and a directed case fixes the triple overlap explicitly.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

    localparam int INSTR_W = 32;
    localparam int OPC_W   = 6;
    localparam int RF_AW   = 5;

    localparam logic [OPC_W-1:0] OPC_REG   = 6'h00;
    localparam logic [OPC_W-1:0] OPC_JMP   = 6'h02;
    localparam logic [OPC_W-1:0] OPC_JMPL  = 6'h03;
    localparam logic [OPC_W-1:0] OPC_BRZ   = 6'h04;
    localparam logic [OPC_W-1:0] OPC_BRNZ  = 6'h05;
    localparam logic [OPC_W-1:0] OPC_LOAD  = 6'h23;
    localparam logic [OPC_W-1:0] OPC_STORE = 6'h2B;

    // field positions (left-origin numbering mapped onto [31:0])
    localparam int OPC_LSB    = 26;
    localparam int RS1_LSB    = 21;
    localparam int RS2_LSB    = 16;
    localparam int RD_REG_LSB = 11;
    localparam int RD_IMM_LSB = 16;
    localparam int IMM_I_W    = 16;
    localparam int IMM_J_W    = 26;

    typedef enum logic [2:0] {
        IC_REG,
        IC_IMM_ALU,
        IC_LOAD,
        IC_STORE,
        IC_BRANCH,
        IC_JUMP,
        IC_OTHER
    } iclass_e;

    typedef struct packed {
        iclass_e          cls;
        logic [RF_AW-1:0] rs1;
        logic [RF_AW-1:0] rs2;
        logic [RF_AW-1:0] rd_reg;
        logic [RF_AW-1:0] rd_imm;
    } ifields_t;

    typedef enum logic [1:0] {
        UP_REG_A = 2'd0,
        UP_NPC   = 2'd1,
        UP_LOAD  = 2'd2
    } up_sel_e;

    typedef enum logic [1:0] {
        LO_REG_B = 2'd0,
        LO_IMM   = 2'd1,
        LO_EXRES = 2'd2
    } lo_sel_e;

    function automatic iclass_e classify(input logic [OPC_W-1:0] opc);
        iclass_e c;
        unique case (opc)
            OPC_REG:             c = IC_REG;
            OPC_LOAD:            c = IC_LOAD;
            OPC_STORE:           c = IC_STORE;
            OPC_BRZ, OPC_BRNZ:   c = IC_BRANCH;
            OPC_JMP, OPC_JMPL:   c = IC_JUMP;
            default: c = (opc[OPC_W-1:3] == 3'b001) ? IC_IMM_ALU : IC_OTHER;
        endcase
        return c;
    endfunction

    function automatic ifields_t split_instr(input logic [INSTR_W-1:0] w);
        ifields_t f;
        f.cls    = classify(w[OPC_LSB +: OPC_W]);
        f.rs1    = w[RS1_LSB +: RF_AW];
        f.rs2    = w[RS2_LSB +: RF_AW];
        f.rd_reg = w[RD_REG_LSB +: RF_AW];
        f.rd_imm = w[RD_IMM_LSB +: RF_AW];
        return f;
    endfunction

    function automatic logic is_flow(input iclass_e c);
        return (c == IC_BRANCH) || (c == IC_JUMP);
    endfunction

    function automatic logic uses_imm(input iclass_e c);
        return (c != IC_REG) && (c != IC_OTHER);
    endfunction

endpackage

// File: rtl/fwd_imm_ext.sv
module fwd_imm_ext
    import fwd_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [INSTR_W-1:0] instr,
    input  iclass_e            cls,
    output logic [DATA_W-1:0]  imm
);
    localparam int PAD_I = DATA_W - IMM_I_W;
    localparam int PAD_J = DATA_W - IMM_J_W;

    logic [DATA_W-1:0] imm_i;
    logic [DATA_W-1:0] imm_j;

    assign imm_i = {{PAD_I{instr[IMM_I_W-1]}}, instr[IMM_I_W-1:0]};
    assign imm_j = {{PAD_J{instr[IMM_J_W-1]}}, instr[IMM_J_W-1:0]};

    always_comb begin
        imm = (cls == IC_JUMP) ? imm_j : imm_i;
    end

    // R4: every bit above the chosen field copies that field's top bit
    always_comb begin
        if (cls == IC_JUMP) begin
            a_r4_jump_sign: assert (imm[DATA_W-1:IMM_J_W-1] == {(PAD_J+1){instr[IMM_J_W-1]}})
                else $error("jump immediate not sign-extended");
        end else begin
            a_r4_short_sign: assert (imm[DATA_W-1:IMM_I_W-1] == {(PAD_I+1){instr[IMM_I_W-1]}})
                else $error("short immediate not sign-extended");
        end
    end

endmodule

// File: rtl/fwd_hazard_ctl.sv
module fwd_hazard_ctl
    import fwd_pkg::*;
(
    input  ifields_t idex_f,
    input  ifields_t exmem_f,
    input  ifields_t memwb_f,
    output up_sel_e  up_sel,
    output lo_sel_e  lo_sel
);
    logic ex_writes;
    logic wb_loads;
    logic ex_hit_rs1;
    logic ex_hit_rs2;
    logic wb_hit_rs1;

    assign ex_writes  = (exmem_f.cls == IC_REG) && (exmem_f.rd_reg != '0);
    assign wb_loads   = (memwb_f.cls == IC_LOAD) && (memwb_f.rd_imm != '0);
    assign ex_hit_rs1 = ex_writes && (exmem_f.rd_reg == idex_f.rs1);
    assign ex_hit_rs2 = ex_writes && (exmem_f.rd_reg == idex_f.rs2);
    assign wb_hit_rs1 = wb_loads && (memwb_f.rd_imm == idex_f.rs1);

    always_comb begin
        if ((idex_f.cls == IC_REG) && (ex_hit_rs1 || ex_hit_rs2)) begin
            lo_sel = LO_EXRES;
        end else if (uses_imm(idex_f.cls)) begin
            lo_sel = LO_IMM;
        end else begin
            lo_sel = LO_REG_B;
        end
    end

    always_comb begin
        if (is_flow(idex_f.cls)) begin
            up_sel = UP_NPC;
        end else if (wb_hit_rs1 && !ex_hit_rs1) begin
            up_sel = UP_LOAD;
        end else begin
            up_sel = UP_REG_A;
        end
    end

    always_comb begin
        // R2: the result bypass only serves a register-format consumer
        if (lo_sel == LO_EXRES) begin
            a_r2_exres_needs_reg: assert (idex_f.cls == IC_REG && exmem_f.cls == IC_REG)
                else $error("result bypass for non register-format pair");
            // R8: destination 0 never bypasses
            a_r8_exres_not_zero: assert (exmem_f.rd_reg != '0)
                else $error("result bypass from register 0");
        end
        if (up_sel == UP_LOAD) begin
            a_r8_load_not_zero: assert (memwb_f.rd_imm != '0)
                else $error("load bypass from register 0");
            // R7: a younger writer of source 1 blocks the load bypass
            a_r7_younger_first: assert (!(exmem_f.cls == IC_REG && exmem_f.rd_reg == idex_f.rs1))
                else $error("load bypass taken over younger result");
        end
        // R5: control-flow opcodes always take the PC
        if (is_flow(idex_f.cls)) begin
            a_r5_flow_takes_npc: assert (up_sel == UP_NPC)
                else $error("flow opcode without PC operand");
        end
    end

endmodule

// File: rtl/fwd_operand_mux.sv
module fwd_operand_mux #(
    parameter int DATA_W = 32,
    parameter int N_IN   = 3,
    parameter int SEL_W  = 2
) (
    input  logic [N_IN-1:0][DATA_W-1:0] din,
    input  logic [SEL_W-1:0]            sel,
    output logic [DATA_W-1:0]           dout
);
    logic [N_IN-1:0][DATA_W-1:0] leg;

    for (genvar k = 0; k < N_IN; k++) begin : g_leg
        assign leg[k] = (sel == SEL_W'(k)) ? din[k] : '0;
    end

    always_comb begin
        dout = '0;
        for (int k = 0; k < N_IN; k++) begin
            dout = dout | leg[k];
        end
    end

    // R9: the select always names a real leg, so an output is always driven
    always_comb begin
        a_r9_sel_in_range: assert (int'(sel) < N_IN)
            else $error("operand select out of range");
    end

endmodule

// File: rtl/alu_operand_fwd.sv
module alu_operand_fwd
    import fwd_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [INSTR_W-1:0] idex_instr,
    input  logic [DATA_W-1:0]  idex_a,
    input  logic [DATA_W-1:0]  idex_b,
    input  logic [DATA_W-1:0]  idex_npc,
    input  logic [INSTR_W-1:0] exmem_instr,
    input  logic [DATA_W-1:0]  exmem_result,
    input  logic [INSTR_W-1:0] memwb_instr,
    input  logic [DATA_W-1:0]  memwb_load_data,
    output logic [DATA_W-1:0]  opnd_up,
    output logic [DATA_W-1:0]  opnd_lo
);
    localparam int N_SRC = 3;
    localparam int SEL_W = $clog2(N_SRC);

    ifields_t idex_f;
    ifields_t exmem_f;
    ifields_t memwb_f;
    up_sel_e  up_sel;
    lo_sel_e  lo_sel;

    logic [DATA_W-1:0]            imm_ext;
    logic [N_SRC-1:0][DATA_W-1:0] up_src;
    logic [N_SRC-1:0][DATA_W-1:0] lo_src;

    assign idex_f  = split_instr(idex_instr);
    assign exmem_f = split_instr(exmem_instr);
    assign memwb_f = split_instr(memwb_instr);

    fwd_imm_ext #(.DATA_W(DATA_W)) imm_i (
        .instr (idex_instr),
        .cls   (idex_f.cls),
        .imm   (imm_ext)
    );

    fwd_hazard_ctl ctl_i (
        .idex_f  (idex_f),
        .exmem_f (exmem_f),
        .memwb_f (memwb_f),
        .up_sel  (up_sel),
        .lo_sel  (lo_sel)
    );

    // leg order follows the select enumerations
    assign up_src = {memwb_load_data, idex_npc, idex_a};
    assign lo_src = {exmem_result, imm_ext, idex_b};

    fwd_operand_mux #(.DATA_W(DATA_W), .N_IN(N_SRC), .SEL_W(SEL_W)) up_mux_i (
        .din  (up_src),
        .sel  (SEL_W'(up_sel)),
        .dout (opnd_up)
    );

    fwd_operand_mux #(.DATA_W(DATA_W), .N_IN(N_SRC), .SEL_W(SEL_W)) lo_mux_i (
        .din  (lo_src),
        .sel  (SEL_W'(lo_sel)),
        .dout (opnd_lo)
    );

endmodule

// File: tb/alu_operand_fwd_tb_top.sv
module alu_operand_fwd_tb_top;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic [31:0] idex_instr, idex_a, idex_b, idex_npc;
    logic [31:0] exmem_instr, exmem_result, memwb_instr, memwb_load_data;
    logic [31:0] opnd_up, opnd_lo;

    int total = 0;
    int bad   = 0;
    int cycles = 0;
    bit done = 0;

    alu_operand_fwd dut_i (
        .idex_instr      (idex_instr),
        .idex_a          (idex_a),
        .idex_b          (idex_b),
        .idex_npc        (idex_npc),
        .exmem_instr     (exmem_instr),
        .exmem_result    (exmem_result),
        .memwb_instr     (memwb_instr),
        .memwb_load_data (memwb_load_data),
        .opnd_up         (opnd_up),
        .opnd_lo         (opnd_lo)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000 && !done) begin
            done = 1;
            bad = bad + 1;
            total = total + 1;
            $display("FAIL watchdog expired act=%0d exp<=100000 cycles", cycles);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    function automatic logic [31:0] mk_r(input logic [5:0] op, input logic [4:0] s1,
                                         input logic [4:0] s2, input logic [4:0] d);
        return {op, s1, s2, d, 11'h000};
    endfunction

    function automatic logic [31:0] mk_i(input logic [5:0] op, input logic [4:0] s1,
                                         input logic [4:0] d, input logic [15:0] imm);
        return {op, s1, d, imm};
    endfunction

    // reference model written from the requirements
    task automatic model(output logic [31:0] eu, output logic [31:0] el,
                         output string tu, output string tl);
        logic [5:0] op   = idex_instr[31:26];
        logic [4:0] s1   = idex_instr[25:21];
        logic [4:0] s2   = idex_instr[20:16];
        logic [5:0] xop  = exmem_instr[31:26];
        logic [4:0] xd   = exmem_instr[15:11];
        logic [5:0] wop  = memwb_instr[31:26];
        logic [4:0] wd   = memwb_instr[20:16];
        bit is_reg  = (op == 6'h00);
        bit is_jump = (op == 6'h02) || (op == 6'h03);
        bit is_flow = is_jump || (op == 6'h04) || (op == 6'h05);
        bit imm_op  = is_flow || (op >= 6'h08 && op <= 6'h0F) || op == 6'h23 || op == 6'h2B;
        bit x_reg   = (xop == 6'h00) && (xd != 0);
        bit ld_hit  = (wop == 6'h23) && (wd != 0) && (wd == s1);
        bit x_hit1  = x_reg && (xd == s1);
        logic [31:0] imm;
        if (is_jump) imm = {{6{idex_instr[25]}}, idex_instr[25:0]};
        else         imm = {{16{idex_instr[15]}}, idex_instr[15:0]};
        if (is_reg && x_reg && (xd == s1 || xd == s2)) begin
            el = exmem_result; tl = "R2";
        end else if (imm_op) begin
            el = imm; tl = "R3/R4";
        end else begin
            el = idex_b; tl = "R3";
        end
        if (is_flow) begin
            eu = idex_npc; tu = "R5";
        end else if (ld_hit && x_hit1) begin
            eu = idex_a; tu = "R7";
        end else if (ld_hit) begin
            eu = memwb_load_data; tu = "R6";
        end else begin
            eu = idex_a; tu = "R6/R8";
        end
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total = total + 1;
        if (act !== exp) begin
            bad = bad + 1;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic apply_and_check(input string note);
        logic [31:0] eu, el;
        string tu, tl;
        @(negedge clk);
        #2;
        model(eu, el, tu, tl);
        chk({tu, " up ", note}, opnd_up, eu);
        chk({tl, " lo ", note}, opnd_lo, el);
    endtask

    task automatic set_data();
        idex_a          = 32'hA0A0_0001;
        idex_b          = 32'hB0B0_0002;
        idex_npc        = 32'h0000_1004;
        exmem_result    = 32'hE0E0_0003;
        memwb_load_data = 32'hD0D0_0004;
    endtask

    function automatic logic [5:0] pick_op(input int unsigned r);
        case (r % 12)
            0, 1, 2: return 6'h00;
            3:       return 6'h23;
            4:       return 6'h2B;
            5:       return 6'h08 + 6'(r % 8);
            6:       return 6'h04;
            7:       return 6'h05;
            8:       return 6'h02;
            9:       return 6'h03;
            10:      return 6'h23;
            default: return 6'h3F;
        endcase
    endfunction

    initial begin
        idex_instr = '0; exmem_instr = '0; memwb_instr = '0;
        idex_a = '0; idex_b = '0; idex_npc = '0; exmem_result = '0; memwb_load_data = '0;
        repeat (3) @(posedge clk);
        rst = 1'b0;

        // reset state: all-zero words, destinations 0, no bypass (R8)
        @(negedge clk); #2;
        chk("R8 reset up", opnd_up, 32'h0);
        chk("R8 reset lo", opnd_lo, 32'h0);

        set_data();
        // R2: source 1 matches younger register-format destination
        idex_instr = mk_r(6'h00, 5'd3, 5'd4, 5'd9);
        exmem_instr = mk_r(6'h00, 5'd1, 5'd2, 5'd3);
        memwb_instr = mk_i(6'h08, 5'd0, 5'd7, 16'h0);
        @(negedge clk); #2;
        chk("R2 rs1 match lo", opnd_lo, 32'hE0E0_0003);
        chk("R6 no load up", opnd_up, 32'hA0A0_0001);

        // R2: source 2 match
        exmem_instr = mk_r(6'h00, 5'd1, 5'd2, 5'd4);
        @(negedge clk); #2;
        chk("R2 rs2 match lo", opnd_lo, 32'hE0E0_0003);

        // R2 negative: producer is a load, not register-format
        exmem_instr = mk_i(6'h23, 5'd1, 5'd3, 16'h0);
        @(negedge clk); #2;
        chk("R2 load producer lo", opnd_lo, 32'hB0B0_0002);

        // R8: destination 0 with source 0
        idex_instr = mk_r(6'h00, 5'd0, 5'd0, 5'd9);
        exmem_instr = mk_r(6'h00, 5'd1, 5'd2, 5'd0);
        memwb_instr = mk_i(6'h23, 5'd1, 5'd0, 16'h0);
        @(negedge clk); #2;
        chk("R8 zero dest lo", opnd_lo, 32'hB0B0_0002);
        chk("R8 zero dest up", opnd_up, 32'hA0A0_0001);

        // R3/R4: immediate ALU op with negative 16-bit immediate
        idex_instr = mk_i(6'h08, 5'd5, 5'd6, 16'h8000);
        exmem_instr = mk_r(6'h00, 5'd1, 5'd2, 5'd5);
        @(negedge clk); #2;
        chk("R4 short sign lo", opnd_lo, 32'hFFFF_8000);

        // R4: jump with bit 25 set, 26-bit extension
        idex_instr = {6'h02, 26'h200_0010};
        @(negedge clk); #2;
        chk("R4 jump sign lo", opnd_lo, 32'hFE00_0010);
        chk("R5 jump up", opnd_up, 32'h0000_1004);

        // R5: branch while a load bypass would match
        idex_instr = mk_i(6'h04, 5'd7, 5'd0, 16'h0020);
        memwb_instr = mk_i(6'h23, 5'd1, 5'd7, 16'h0);
        exmem_instr = '0;
        @(negedge clk); #2;
        chk("R5 branch up", opnd_up, 32'h0000_1004);
        chk("R3 branch lo", opnd_lo, 32'h0000_0020);

        // R6: load bypass into source 1
        idex_instr = mk_r(6'h00, 5'd7, 5'd2, 5'd9);
        @(negedge clk); #2;
        chk("R6 load bypass up", opnd_up, 32'hD0D0_0004);

        // R7: both older instructions write source 1; younger wins
        exmem_instr = mk_r(6'h00, 5'd1, 5'd2, 5'd7);
        @(negedge clk); #2;
        chk("R7 younger first up", opnd_up, 32'hA0A0_0001);
        chk("R7 result on lo", opnd_lo, 32'hE0E0_0003);

        // R3: unrecognised opcode takes B
        idex_instr = {6'h3F, 26'h3FF_FFFF};
        exmem_instr = '0;
        memwb_instr = '0;
        @(negedge clk); #2;
        chk("R3 other lo", opnd_lo, 32'hB0B0_0002);

        // R9: outputs follow inputs without a clock edge
        @(posedge clk); #3;
        idex_b = 32'h1234_5678;
        idex_a = 32'h8765_4321;
        #2;
        chk("R9 comb lo", opnd_lo, 32'h1234_5678);
        chk("R9 comb up", opnd_up, 32'h8765_4321);

        // constrained random with a fixed seed
        void'($urandom(32'd1357));
        for (int n = 0; n < 600; n++) begin
            int unsigned r0 = $urandom;
            int unsigned r1 = $urandom;
            int unsigned r2 = $urandom;
            logic [4:0] pool [4] = '{5'd0, 5'd1, 5'd2, 5'd3};
            idex_instr  = {pick_op(r0), pool[r0[9:8]], pool[r0[11:10]], pool[r0[13:12]],
                           r0[15] ? 11'h7FF : 11'(r1)};
            exmem_instr = {pick_op(r1), pool[r1[9:8]], pool[r1[11:10]], pool[r1[13:12]], 11'(r2)};
            memwb_instr = {pick_op(r2), pool[r2[9:8]], pool[r2[11:10]], pool[r2[13:12]], 11'(r0)};
            idex_a = $urandom; idex_b = $urandom; idex_npc = $urandom;
            exmem_result = $urandom; memwb_load_data = $urandom;
            apply_and_check("random");
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule